// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing protocol engine of a 512-byte serial EEPROM. It watches the two-wire clock and data lines. A much faster system clock oversamples both lines, and the engine finds start and stop conditions from the sampled levels. It receives the device select byte and compares it with two strap inputs. On writes it takes the word address and then the data bytes. It acknowledges each byte it accepts and shifts read data out most significant bit first. It never drives the data line high. It only asserts an output enable, and the pad pulls the line low while that enable is set.

The engine keeps one 9-bit address counter that lives across transactions. A write loads the counter. The counter then steps after every data byte, whether that byte was received or sent. This makes current-address reads, random reads (a dummy write followed by a repeated start) and sequential reads work. The counter wraps from 511 to 0.

Toward the storage side the engine offers two paths:
- A combinational read port, addressed by the counter.
- A write-byte handoff to a separate page-programming controller, with a commit pulse on a well-formed stop.

While that controller reports busy, the engine ignores the bus entirely, so a master can poll for completion by watching for the acknowledge.

Top module: `eep_i2c_slave`

## Requirements
- R1: A start is a falling data line while the clock stays high. A stop is a rising data line while the clock stays high. After a stop the engine is idle with the data line released.
- R2: The select byte is compared in bits 7..2 against `1010`, `strap_a2`, `strap_a1`. Bit 1 is address bit 8 and bit 0 is the direction (1 = read). On a mismatch the engine does not acknowledge and ignores the bus until the next start.
- R3: The engine acknowledges a matching select byte, the word address byte and every write data byte. It does so by pulling the data line low for the whole 9th clock.
- R4: In a write, the second byte and bit 1 of the select byte load the counter. Each later data byte appears on a one-cycle `wr_valid` pulse, with `wr_addr` set to the counter value, and the counter then steps by one.
- R5: `wr_commit` pulses only for a stop that comes right after the rising clock edge following a data-byte acknowledge, and only if at least one data byte was received. A stop later in a byte, or after a dummy write, produces no commit.
- R6: A read sends the byte at the current counter, MSB first. Each bit is placed after a falling clock edge. The counter steps after every byte sent. Bit 1 of a read select byte does not change the counter.
- R7: A master acknowledge after a read byte starts the next byte at the stepped counter. A master non-acknowledge returns the engine to idle with the data line released.
- R8: The counter wraps from 511 to 0, for both write bytes and read bytes.
- R9: While `prog_busy` is high, a start is ignored and the select byte is not acknowledged.
- R10: A start inside any byte aborts the transfer in progress, and the next eight bits are taken as a new select byte.
- R11: The engine changes `sda_oe` only in response to a falling clock edge, a start or a stop.
- R12: After reset `sda_oe` is low, `wr_valid` and `wr_commit` are low, and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_oe | output | 1 | When high the pad pulls the data line low |
| strap_a2 | input | 1 | Upper select strap |
| strap_a1 | input | 1 | Lower select strap |
| mem_raddr | output | 9 | Read address, equal to the counter |
| mem_rdata | input | 8 | Byte stored at `mem_raddr`, valid in the same cycle |
| wr_valid | output | 1 | One-cycle pulse: a write byte is handed over |
| wr_addr | output | 9 | Target address of the handed byte |
| wr_data | output | 8 | Handed write byte |
| wr_commit | output | 1 | One-cycle pulse: start programming the handed bytes |
| prog_busy | input | 1 | Programming controller is busy |

## Verification
Two situations are hard to reach from the ports. The first is the narrow window that separates a committing stop from an aborting one: exactly one rising clock edge after the data acknowledge, compared with a stop a few bits later. The second is the busy window just after a commit, in which the select byte must go unanswered. The master tasks can end a write after any chosen number of bits, and a polling loop starts right after the commit pulse. Together they cover both edges of each window. The bench then reads back the address and the neighbour it could have touched, which shows whether memory and the counter changed.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W = 9;
  localparam int BYTE_W = 8;
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADR,
    ST_WR,
    ST_RD
  } eng_state_e;

  // select byte: [7:4] type code, [3] strap A2, [2] strap A1, [1] addr bit 8, [0] direction
  function automatic logic dev_hit(input logic [BYTE_W-1:0] b, input logic a2, input logic a1);
    return (b[7:4] == TYPE_CODE) && (b[3] == a2) && (b[2] == a1);
  endfunction

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_lvl;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  assign scl_lvl = scl_pipe[STAGES-1];
  assign sda_lvl = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/eep_bit_unit.sv
module eep_bit_unit import eep_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic              sample,
  input  logic              din,
  output logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] shreg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en && sample) begin
      cnt   <= cnt + CNT_W'(1);
      shreg <= {shreg[BYTE_W-2:0], din};
    end
  end
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr import eep_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              inc,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] ctr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctr <= '0;
    else if (load) ctr <= load_val;
    else if (inc)  ctr <= addr_next(ctr);
  end
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave import eep_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              strap_a2,
  input  logic              strap_a1,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit,
  input  logic              prog_busy
);
  localparam int CNT_W = $clog2(BYTE_W + 2);

  logic              sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_byte;
  logic [ADDR_W-1:0] ctr_q;
  eng_state_e        state_q;
  logic              ack_q, rw_q, b8_q, mack_q, have_data_q;
  logic [BYTE_W-1:0] tx_q;

  // named internal events
  logic byte_end, ack_end, bit_clr, ctr_load, ctr_inc, commit_ok, bit_en;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign byte_end  = scl_fall && !ack_q && (bit_cnt == CNT_W'(BYTE_W));
  assign ack_end   = scl_fall && ack_q;
  assign bit_clr   = start_ev || ack_end;
  assign bit_en    = (state_q != ST_IDLE);
  assign ctr_load  = (state_q == ST_ADR) && byte_end;
  assign ctr_inc   = byte_end && ((state_q == ST_WR) || (state_q == ST_RD));
  assign commit_ok = (state_q == ST_WR) && have_data_q && !ack_q && (bit_cnt == CNT_W'(1));

  eep_bit_unit #(.CNT_W(CNT_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .en(bit_en), .clr(bit_clr),
    .sample(scl_rise), .din(sda_lvl), .cnt(bit_cnt), .shreg(rx_byte)
  );

  eep_addr_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .inc(ctr_inc),
    .load_val({b8_q, rx_byte}), .ctr(ctr_q)
  );

  assign mem_raddr = ctr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ack_q       <= 1'b0;
      sda_oe      <= 1'b0;
      rw_q        <= 1'b0;
      b8_q        <= 1'b0;
      mack_q      <= 1'b0;
      have_data_q <= 1'b0;
      tx_q        <= '0;
      wr_valid    <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      wr_commit   <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (start_ev) begin
        ack_q       <= 1'b0;
        sda_oe      <= 1'b0;
        mack_q      <= 1'b0;
        have_data_q <= 1'b0;
        state_q     <= prog_busy ? ST_IDLE : ST_DEV;
      end else if (stop_ev) begin
        wr_commit   <= commit_ok;
        ack_q       <= 1'b0;
        sda_oe      <= 1'b0;
        mack_q      <= 1'b0;
        have_data_q <= 1'b0;
        state_q     <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_DEV: begin
            if (byte_end) begin
              if (dev_hit(rx_byte, strap_a2, strap_a1) && !prog_busy) begin
                ack_q  <= 1'b1;
                sda_oe <= 1'b1;
                rw_q   <= rx_byte[0];
                b8_q   <= rx_byte[1];
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (ack_end) begin
              ack_q <= 1'b0;
              if (rw_q) begin
                state_q <= ST_RD;
                tx_q    <= mem_rdata;
                sda_oe  <= ~mem_rdata[BYTE_W-1];
              end else begin
                state_q <= ST_ADR;
                sda_oe  <= 1'b0;
              end
            end
          end
          ST_ADR, ST_WR: begin
            if (byte_end) begin
              ack_q  <= 1'b1;
              sda_oe <= 1'b1;
              if (state_q == ST_WR) begin
                wr_valid    <= 1'b1;
                wr_addr     <= ctr_q;
                wr_data     <= rx_byte;
                have_data_q <= 1'b1;
              end
            end else if (ack_end) begin
              ack_q   <= 1'b0;
              sda_oe  <= 1'b0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (!ack_q) begin
              if (scl_fall) begin
                if (bit_cnt == CNT_W'(BYTE_W)) begin
                  sda_oe <= 1'b0;
                  ack_q  <= 1'b1;
                  mack_q <= 1'b0;
                end else begin
                  tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                  sda_oe <= ~tx_q[BYTE_W-2];
                end
              end
            end else begin
              if (scl_rise) begin
                if (sda_lvl) state_q <= ST_IDLE;
                else         mack_q  <= 1'b1;
              end else if (scl_fall && mack_q) begin
                ack_q  <= 1'b0;
                mack_q <= 1'b0;
                tx_q   <= mem_rdata;
                sda_oe <= ~mem_rdata[BYTE_W-1];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eep_i2c_checker.sv
module eep_i2c_checker import eep_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_fall,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              prog_busy,
  input logic              ctr_inc,
  input logic              wr_valid,
  input logic              wr_commit,
  input eng_state_e        state,
  input logic [ADDR_W-1:0] ctr
);
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE)) else $error("stop did not idle"); // R1

  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall)) else $error("sda driven off a fall"); // R11

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && prog_busy) |=> (state == ST_IDLE)) else $error("start taken while busy"); // R9

  AST_COUNTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_inc && (ctr == {ADDR_W{1'b1}})) |=> (ctr == '0)) else $error("no wrap"); // R8

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid) else $error("wr_valid longer than a cycle"); // R4

  AST_COMMIT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !wr_valid) else $error("commit overlaps byte"); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe) else $error("idle but driving"); // R7
endmodule

bind eep_i2c_slave eep_i2c_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_ev(start_ev), .stop_ev(stop_ev), .prog_busy(prog_busy),
  .ctr_inc(ctr_inc), .wr_valid(wr_valid), .wr_commit(wr_commit),
  .state(state_q), .ctr(ctr_q)
);

// File: tb/test_eep_i2c_slave.sv
module test_eep_i2c_slave;
  import eep_pkg::*;
  localparam int Q = 10;
  localparam int BUSY_CYC = 800;
  localparam logic S_A2 = 1'b1;
  localparam logic S_A1 = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_bus, sda_oe;
  logic [8:0] mem_raddr, wr_addr;
  logic [7:0] mem_rdata, wr_data;
  logic wr_valid, wr_commit, prog_busy;

  assign sda_bus = m_sda & ~sda_oe;

  eep_i2c_slave i_eep_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_a2(S_A2), .strap_a1(S_A1), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .prog_busy(prog_busy)
  );

  // storage and page-programming controller model
  logic [7:0] mem [512];
  logic [8:0] pend_a [64];
  logic [7:0] pend_d [64];
  logic [8:0] wv_log [64];
  int pend_n, busy_cnt, wv_cnt;
  logic flush_req = 1'b0;

  function automatic logic [7:0] init_pat(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  assign mem_rdata = mem[mem_raddr];
  assign prog_busy = (busy_cnt != 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= init_pat(i);
      pend_n <= 0; busy_cnt <= 0; wv_cnt <= 0;
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (flush_req) begin
        pend_n <= 0; wv_cnt <= 0;
      end else if (wr_valid) begin
        if (pend_n < 64) begin
          pend_a[pend_n] <= wr_addr; pend_d[pend_n] <= wr_data; wv_log[pend_n] <= wr_addr;
        end
        pend_n <= pend_n + 1; wv_cnt <= wv_cnt + 1;
      end
      if (wr_commit) begin
        for (int k = 0; k < pend_n; k++) mem[pend_a[k]] <= pend_d[k];
        pend_n <= 0; busy_cnt <= BUSY_CYC;
      end
    end
  end

  // reference state
  logic [7:0] exp_mem [512];
  logic [8:0] exp_ctr;
  logic [7:0] wbuf [16];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  function automatic logic [7:0] dev_byte(input logic b8, input logic rw);
    return {4'b1010, S_A2, S_A1, b8, rw};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    flush_req = 1'b1;
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; flush_req = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q / 2);
    acked = !sda_bus;
    tick(Q / 2);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q / 2);
      b[i] = sda_bus;
      tick(Q / 2);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = !mack; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * BUSY_CYC && prog_busy; i++) tick(1);
  endtask

  task automatic do_write(input logic [8:0] addr, input int n, input bit poll);
    bit ack;
    int tries;
    i2c_start();
    send_byte(dev_byte(addr[8], 1'b0), ack); chk_eq("R3 write select ack", ack, 1);
    send_byte(addr[7:0], ack);               chk_eq("R3 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack); chk_eq("R3 data byte ack", ack, 1);
    end
    i2c_stop();
    chk_eq("R4 handed byte count", wv_cnt, n);
    for (int k = 0; k < n && k < 4; k++)
      chk_eq("R8 R4 handed address", wv_log[k], 32'((addr + 9'(k)) & 9'h1FF));
    for (int k = 0; k < n; k++) exp_mem[9'(addr + 9'(k))] = wbuf[k];
    exp_ctr = addr + 9'(n);
    chk_eq("R5 commit only with data", prog_busy, (n > 0) ? 1 : 0);
    if (poll && n > 0) begin
      i2c_start();
      send_byte(dev_byte(1'b0, 1'b0), ack);
      chk_eq("R9 no ack while busy", ack, 0);
      i2c_stop();
      tries = 0;
      ack = 0;
      while (!ack && tries < 20) begin
        i2c_start();
        send_byte(dev_byte(1'b0, 1'b0), ack);
        i2c_stop();
        tries++;
      end
      chk_eq("R9 ack once idle", ack, 1);
      chk_eq("R9 ack only after busy", prog_busy, 0);
    end else begin
      wait_idle();
    end
  endtask

  task automatic do_read(input bit set_addr, input logic [8:0] addr, input int n, input bit flip_b8);
    bit ack;
    logic [7:0] b;
    if (set_addr) begin
      i2c_start();
      send_byte(dev_byte(addr[8], 1'b0), ack); chk_eq("R3 dummy select ack", ack, 1);
      send_byte(addr[7:0], ack);               chk_eq("R4 dummy address ack", ack, 1);
      exp_ctr = addr;
    end
    i2c_start();
    send_byte(dev_byte(exp_ctr[8] ^ flip_b8, 1'b1), ack); chk_eq("R2 read select ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk_eq((k == 0) ? "R6 read byte" : "R7 sequential byte", b, exp_mem[exp_ctr]);
      exp_ctr = exp_ctr + 9'd1;
    end
    tick(2);
    chk_eq("R7 released after nack", sda_oe, 0);
    i2c_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    void'($urandom(32'd20417));
    for (int i = 0; i < 512; i++) exp_mem[i] = init_pat(i);
    exp_ctr = '0;
    tick(5);
    chk_eq("R12 sda_oe after reset", sda_oe, 0);
    chk_eq("R12 wr_valid after reset", wr_valid, 0);
    rst_n = 1'b1;
    tick(5);
    chk_eq("R12 counter after reset", mem_raddr, 0);
    chk_eq("R12 commit after reset", wr_commit, 0);

    // R6 current address read from reset counter
    do_read(1'b0, 9'h0, 2, 1'b0);

    // R8 write across the top, with busy polling (R9)
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h7E;
    do_write(9'h1FE, 3, 1'b1);
    do_read(1'b1, 9'h1FD, 5, 1'b0);

    // R6 select bit 1 ignored on reads
    do_read(1'b0, 9'h0, 1, 1'b1);

    // R2 mismatching strap and type code
    i2c_start();
    send_byte({4'b1010, ~S_A2, S_A1, 2'b00}, ack); chk_eq("R2 strap mismatch nack", ack, 0);
    send_byte(dev_byte(1'b0, 1'b0), ack);          chk_eq("R2 waits for next start", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte({4'b1011, S_A2, S_A1, 2'b00}, ack);  chk_eq("R2 type mismatch nack", ack, 0);
    i2c_stop();

    // R5 stop inside a byte: handed but not committed
    i2c_start();
    send_byte(dev_byte(1'b0, 1'b0), ack);
    send_byte(8'h40, ack);
    send_byte(8'hEE, ack); chk_eq("R3 data ack before abort", ack, 1);
    send_bits(8'hFF, 3);
    i2c_stop();
    chk_eq("R5 no commit on mid-byte stop", prog_busy, 0);
    chk_eq("R4 byte handed before abort", wv_cnt, 1);
    exp_ctr = 9'h041;
    do_read(1'b0, 9'h0, 1, 1'b0);
    do_read(1'b1, 9'h040, 1, 1'b0);

    // R5 dummy write alone
    do_write(9'h123, 0, 1'b0);

    // R10 start inside a byte
    i2c_start();
    send_bits(8'h5A, 4);
    i2c_start();
    send_byte(dev_byte(1'b0, 1'b0), ack); chk_eq("R10 new select after abort", ack, 1);
    send_byte(8'h77, ack);
    exp_ctr = 9'h077;
    do_read(1'b0, 9'h0, 1, 1'b0);

    // random mix
    for (int t = 0; t < 24; t++) begin
      int op, n;
      logic [8:0] a;
      op = int'($urandom % 3);
      a  = 9'($urandom);
      if (op == 0) begin
        n = 1 + int'($urandom % 4);
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        do_write(a, n, 1'b0);
      end else if (op == 1) begin
        do_read(1'b1, a, 1 + int'($urandom % 3), 1'($urandom));
      end else begin
        do_read(1'b0, 9'h0, 1 + int'($urandom % 2), 1'($urandom));
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule